// File: doc/BRIEF.md
# Pipelined Control Signal Carrier

This block carries the control decisions of a five-stage in-order pipeline from the decode stage down to the stages that act on them. An opcode and a destination register number enter at the fetch side and are latched at the fetch/decode boundary. A small main decoder turns the opcode into a nine-bit control word. That word is then shed group by group. The execute group is dropped after the decode/execute boundary. The memory group is dropped after the execute/memory boundary. Only the writeback group reaches the memory/writeback boundary. The destination number rides beside the control bits at every boundary, so writeback always names the register of its own instruction and never that of whatever sits in decode.

A hazard unit outside this block drives three pipeline controls. A decode stall freezes the fetch/decode boundary. A decode flush zeroes that boundary, which leaves an all-zero word that decodes as a harmless write to register 0. An execute flush zeroes every control bit entering execute, which makes a bubble that carries no register or memory write. For a load-use stall the hazard unit raises the decode stall and the execute flush together. An active-low asynchronous reset clears all boundary registers.

Top module: `ctrl_pipe_carrier`

## Requirements
- R1: The decoder maps opcodes to control words as follows. The word is written {ex[3:0], mem[2:0], wb[1:0]}, where ex = {dst_sel, alu_op[1:0], alu_src}, mem = {branch, mem_rd, mem_wr} and wb = {reg_wr, mem_to_reg}. Opcode 6'h00 (register-register) gives ex=1100, mem=000, wb=10. Opcode 6'h23 (load) gives ex=0001, mem=010, wb=11. Opcode 6'h2B (store) gives ex=0001, mem=001, wb=00. Opcode 6'h04 (branch on equal) gives ex=0010, mem=100, wb=00.
- R2: Any other opcode decodes to all nine control bits zero.
- R3: An opcode that is present before clock edge n appears on ex_ctrl_o after edge n+1, on mem_ctrl_o after edge n+2 and on wb_ctrl_o after edge n+3. The mem_wr bit of a store therefore reaches the memory stage in the instruction's fourth cycle.
- R4: The destination number moves in step with its control groups. dst_e_o, dst_m_o and dst_w_o each belong to the instruction whose groups are on ex_ctrl_o, mem_ctrl_o and wb_ctrl_o at the same time.
- R5: While stall_d_i is high and flush_d_i is low, the fetch/decode boundary holds its contents and ignores op_i and dst_i. The held instruction is presented to execute again at every stalled edge.
- R6: When flush_e_i is high at an edge, all nine control bits captured at the decode/execute boundary are zero, while the destination number is still captured. The resulting bubble travels on through memory and writeback with zero control bits.
- R7: When flush_d_i is high at an edge, the fetch/decode boundary loads opcode 0 and destination 0, even if stall_d_i is also high. That slot reaches execute as ex=1100 with dst_e_o=0, and it reaches writeback as wb=10 with dst_w_o=0.
- R8: Driving rst_ni low clears every control output and every destination output at once, without waiting for a clock edge.
- R9: When stall_d_i and flush_e_i are high in the same cycle, execute receives a bubble at that edge. The held decode instruction enters execute intact at the next edge after both are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | OP_W | Opcode of the instruction being fetched |
| dst_i | input | REG_W | Destination register number of the fetched instruction |
| stall_d_i | input | 1 | Hold the fetch/decode boundary |
| flush_d_i | input | 1 | Zero the fetch/decode boundary (wins over stall) |
| flush_e_i | input | 1 | Zero the control bits entering execute |
| ex_ctrl_o | output | 4 | Execute group {dst_sel, alu_op[1:0], alu_src} |
| dst_e_o | output | REG_W | Destination number in execute |
| mem_ctrl_o | output | 3 | Memory group {branch, mem_rd, mem_wr} |
| dst_m_o | output | REG_W | Destination number in memory |
| wb_ctrl_o | output | 2 | Writeback group {reg_wr, mem_to_reg} |
| dst_w_o | output | REG_W | Destination number in writeback |

## Verification
Two functions can meet in the same cycle, and the bench provokes both meetings directly. In the first, a decode stall and an execute flush fall on one edge. The bench loads a store into decode, raises both controls together while a different instruction waits at the inputs, and then releases them. Execute must show a bubble that carries the store's destination and then the intact store, memory must show the bubble one edge later, and the waiting instruction must follow in order. In the second, a decode flush meets a decode stall. The bench expects the flush to win, which it judges by an R-type write to register 0 appearing in execute and later in writeback.

// File: rtl/pipe_ctrl_pkg.sv
package pipe_ctrl_pkg;

  localparam int OP_W_DEF  = 6;
  localparam int REG_W_DEF = 5;

  localparam logic [OP_W_DEF-1:0] OPC_RR    = 6'h00;
  localparam logic [OP_W_DEF-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W_DEF-1:0] OPC_STORE = 6'h2B;
  localparam logic [OP_W_DEF-1:0] OPC_BEQ   = 6'h04;

  typedef struct packed {
    logic       dst_sel;
    logic [1:0] alu_op;
    logic       alu_src;
  } ex_grp_t;

  typedef struct packed {
    logic branch;
    logic mem_rd;
    logic mem_wr;
  } mem_grp_t;

  typedef struct packed {
    logic reg_wr;
    logic mem_to_reg;
  } wb_grp_t;

  typedef struct packed {
    ex_grp_t  ex;
    mem_grp_t mem;
    wb_grp_t  wb;
  } ctrl_word_t;

  localparam int EX_W   = $bits(ex_grp_t);
  localparam int MEM_W  = $bits(mem_grp_t);
  localparam int WB_W   = $bits(wb_grp_t);
  localparam int CTRL_W = $bits(ctrl_word_t);

endpackage

// File: rtl/pipe_bnd_reg.sv
module pipe_bnd_reg #(
  parameter int CW       = 1,
  parameter int DW       = 1,
  parameter bit CLR_DATA = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [CW-1:0] ctrl_d_i,
  input  logic [DW-1:0] data_d_i,
  output logic [CW-1:0] ctrl_q_o,
  output logic [DW-1:0] data_q_o
);

  // clear wins over capture; control bits always cleared
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q_o <= '0;
    else if (clr_i)  ctrl_q_o <= '0;
    else if (en_i)   ctrl_q_o <= ctrl_d_i;
  end

  generate
    if (CLR_DATA) begin : g_clr_data
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     data_q_o <= '0;
        else if (clr_i)  data_q_o <= '0;
        else if (en_i)   data_q_o <= data_d_i;
      end
    end else begin : g_keep_data
      // data still moves with a flushed slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                data_q_o <= '0;
        else if (en_i || clr_i)     data_q_o <= data_d_i;
      end
    end
  endgenerate

  AST_CLR_ZEROES_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ctrl_q_o == '0)); // R6

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> ($stable(ctrl_q_o) && $stable(data_q_o))); // R5

endmodule

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
  import pipe_ctrl_pkg::*;
#(
  parameter int OP_W = OP_W_DEF
) (
  input  logic [OP_W-1:0] op_i,
  output ctrl_word_t      word_o
);

  always_comb begin
    word_o = '0;
    unique case (op_i)
      OP_W'(OPC_RR): begin
        word_o.ex.dst_sel = 1'b1;
        word_o.ex.alu_op  = 2'b10;
        word_o.wb.reg_wr  = 1'b1;
      end
      OP_W'(OPC_LOAD): begin
        word_o.ex.alu_src    = 1'b1;
        word_o.mem.mem_rd    = 1'b1;
        word_o.wb.reg_wr     = 1'b1;
        word_o.wb.mem_to_reg = 1'b1;
      end
      OP_W'(OPC_STORE): begin
        word_o.ex.alu_src = 1'b1;
        word_o.mem.mem_wr = 1'b1;
      end
      OP_W'(OPC_BEQ): begin
        word_o.ex.alu_op  = 2'b01;
        word_o.mem.branch = 1'b1;
      end
      default: word_o = '0;
    endcase
  end

endmodule

// File: rtl/ctrl_pipe_carrier.sv
module ctrl_pipe_carrier
  import pipe_ctrl_pkg::*;
#(
  parameter int OP_W  = OP_W_DEF,
  parameter int REG_W = REG_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  op_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             stall_d_i,
  input  logic             flush_d_i,
  input  logic             flush_e_i,
  output logic [3:0]       ex_ctrl_o,
  output logic [REG_W-1:0] dst_e_o,
  output logic [2:0]       mem_ctrl_o,
  output logic [REG_W-1:0] dst_m_o,
  output logic [1:0]       wb_ctrl_o,
  output logic [REG_W-1:0] dst_w_o
);

  localparam int XM_W = MEM_W + WB_W;

  logic [OP_W-1:0]  op_d;
  logic [REG_W-1:0] dst_d;
  ctrl_word_t       ctrl_d;
  ctrl_word_t       ctrl_e;
  logic [XM_W-1:0]  xm_q;
  logic [WB_W-1:0]  mw_q;

  // fetch/decode: flush yields an all-zero (harmless) instruction
  pipe_bnd_reg #(.CW(OP_W), .DW(REG_W), .CLR_DATA(1'b1)) u_if_id (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (~stall_d_i),
    .clr_i   (flush_d_i),
    .ctrl_d_i(op_i),
    .data_d_i(dst_i),
    .ctrl_q_o(op_d),
    .data_q_o(dst_d)
  );

  ctrl_main_dec #(.OP_W(OP_W)) u_dec (
    .op_i  (op_d),
    .word_o(ctrl_d)
  );

  // decode/execute: all nine bits enter, flush makes a bubble
  pipe_bnd_reg #(.CW(CTRL_W), .DW(REG_W), .CLR_DATA(1'b0)) u_id_ex (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (1'b1),
    .clr_i   (flush_e_i),
    .ctrl_d_i(ctrl_d),
    .data_d_i(dst_d),
    .ctrl_q_o(ctrl_e),
    .data_q_o(dst_e_o)
  );

  // execute/memory: execute group peeled off
  pipe_bnd_reg #(.CW(XM_W), .DW(REG_W), .CLR_DATA(1'b0)) u_ex_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (1'b1),
    .clr_i   (1'b0),
    .ctrl_d_i({ctrl_e.mem, ctrl_e.wb}),
    .data_d_i(dst_e_o),
    .ctrl_q_o(xm_q),
    .data_q_o(dst_m_o)
  );

  // memory/writeback: only writeback group remains
  pipe_bnd_reg #(.CW(WB_W), .DW(REG_W), .CLR_DATA(1'b0)) u_mem_wb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (1'b1),
    .clr_i   (1'b0),
    .ctrl_d_i(xm_q[WB_W-1:0]),
    .data_d_i(dst_m_o),
    .ctrl_q_o(mw_q),
    .data_q_o(dst_w_o)
  );

  assign ex_ctrl_o  = ctrl_e.ex;
  assign mem_ctrl_o = xm_q[WB_W +: MEM_W];
  assign wb_ctrl_o  = mw_q;

  // assertion support: one clean cycle after reset before $past is trusted
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  AST_DEC_MEM_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_d.mem.branch, ctrl_d.mem.mem_rd, ctrl_d.mem.mem_wr})); // R1

  AST_STORE_NO_REGWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_d.mem.mem_wr |-> !ctrl_d.wb.reg_wr); // R1

  AST_MEM_FOLLOWS_EX: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok_q)
    mem_ctrl_o == $past(ctrl_e.mem)); // R3

  AST_DST_RIDES_WB: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok_q)
    (dst_w_o == $past(dst_m_o)) && (wb_ctrl_o == $past(xm_q[WB_W-1:0]))); // R4

endmodule

// File: tb/ctrl_pipe_carrier_tb.sv
`timescale 1ns/1ps
module ctrl_pipe_carrier_tb;

  localparam int OP_W  = 6;
  localparam int REG_W = 5;
  localparam int N_VEC = 12;

  // {op[19:14], dst[13:9], ex[8:5], mem[4:2], wb[1:0]}
  localparam logic [19:0] VEC [N_VEC] = '{
    {6'h00, 5'd3,  9'b1100_000_10},
    {6'h23, 5'd9,  9'b0001_010_11},
    {6'h2B, 5'd4,  9'b0001_001_00},
    {6'h04, 5'd0,  9'b0010_100_00},
    {6'h3F, 5'd31, 9'b0000_000_00},
    {6'h00, 5'd17, 9'b1100_000_10},
    {6'h2B, 5'd1,  9'b0001_001_00},
    {6'h23, 5'd31, 9'b0001_010_11},
    {6'h08, 5'd2,  9'b0000_000_00},
    {6'h00, 5'd0,  9'b1100_000_10},
    {6'h04, 5'd12, 9'b0010_100_00},
    {6'h00, 5'd5,  9'b1100_000_10}
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [OP_W-1:0]  op_i = '0;
  logic [REG_W-1:0] dst_i = '0;
  logic             stall_d_i = 1'b0;
  logic             flush_d_i = 1'b0;
  logic             flush_e_i = 1'b0;
  logic [3:0]       ex_ctrl_o;
  logic [REG_W-1:0] dst_e_o;
  logic [2:0]       mem_ctrl_o;
  logic [REG_W-1:0] dst_m_o;
  logic [1:0]       wb_ctrl_o;
  logic [REG_W-1:0] dst_w_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ctrl_pipe_carrier #(.OP_W(OP_W), .REG_W(REG_W)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .op_i      (op_i),
    .dst_i     (dst_i),
    .stall_d_i (stall_d_i),
    .flush_d_i (flush_d_i),
    .flush_e_i (flush_e_i),
    .ex_ctrl_o (ex_ctrl_o),
    .dst_e_o   (dst_e_o),
    .mem_ctrl_o(mem_ctrl_o),
    .dst_m_o   (dst_m_o),
    .wb_ctrl_o (wb_ctrl_o),
    .dst_w_o   (dst_w_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [OP_W-1:0] op, input logic [REG_W-1:0] dst);
    op_i  = op;
    dst_i = dst;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R8: reset state
    #12;
    chk("R8 reset ex", ex_ctrl_o, 0);
    chk("R8 reset mem", mem_ctrl_o, 0);
    chk("R8 reset wb", wb_ctrl_o, 0);
    chk("R8 reset dst_w", dst_w_o, 0);
    @(posedge clk);
    #1 rst_ni = 1'b1;

    // table walk: R1 R2 R3 R4
    for (int j = 0; j < N_VEC; j++) begin
      drive(VEC[j][19:14], VEC[j][13:9]);
      step();
      if (j >= 1) begin
        chk("R1/R2 ex group", ex_ctrl_o, VEC[j-1][8:5]);
        chk("R4 dst_e", dst_e_o, VEC[j-1][13:9]);
      end
      if (j >= 2) begin
        chk("R3 mem group", mem_ctrl_o, VEC[j-2][4:2]);
        chk("R4 dst_m", dst_m_o, VEC[j-2][13:9]);
      end
      if (j >= 3) begin
        chk("R3 wb group", wb_ctrl_o, VEC[j-3][1:0]);
        chk("R4 dst_w", dst_w_o, VEC[j-3][13:9]);
      end
    end

    // R5: stall holds decode, inputs ignored
    drive(6'h23, 5'd6);
    step();
    drive(6'h00, 5'd21);
    stall_d_i = 1'b1;
    step();
    chk("R5 ex first", ex_ctrl_o, 4'b0001);
    step();
    chk("R5 ex repeated", ex_ctrl_o, 4'b0001);
    chk("R5 dst_e held", dst_e_o, 6);
    chk("R3 load mem group", mem_ctrl_o, 3'b010);
    stall_d_i = 1'b0;
    step();
    step();
    chk("R5 waiting instr ex", ex_ctrl_o, 4'b1100);
    chk("R5 waiting instr dst", dst_e_o, 21);

    // R9 / R6: stall and execute flush together
    drive(6'h2B, 5'd9);
    step();
    drive(6'h04, 5'd3);
    stall_d_i = 1'b1;
    flush_e_i = 1'b1;
    step();
    chk("R6 bubble ex", ex_ctrl_o, 0);
    chk("R6 bubble keeps dst", dst_e_o, 9);
    stall_d_i = 1'b0;
    flush_e_i = 1'b0;
    step();
    chk("R9 store enters ex", ex_ctrl_o, 4'b0001);
    chk("R9 store dst", dst_e_o, 9);
    chk("R6 bubble mem", mem_ctrl_o, 0);
    step();
    chk("R9 next instr ex", ex_ctrl_o, 4'b0010);
    chk("R3 store mem_wr", mem_ctrl_o, 3'b001);
    chk("R6 bubble wb", wb_ctrl_o, 0);
    chk("R6 bubble dst_w", dst_w_o, 9);

    // R7: decode flush beats stall
    drive(6'h2B, 5'd7);
    step();
    drive(6'h3F, 5'd11);
    stall_d_i = 1'b1;
    flush_d_i = 1'b1;
    step();
    stall_d_i = 1'b0;
    flush_d_i = 1'b0;
    step();
    chk("R7 zero instr ex", ex_ctrl_o, 4'b1100);
    chk("R7 zero instr dst", dst_e_o, 0);
    step();
    chk("R2 unknown op ex", ex_ctrl_o, 0);
    chk("R2 unknown op dst", dst_e_o, 11);
    step();
    chk("R7 zero instr wb", wb_ctrl_o, 2'b10);
    chk("R7 zero instr dst_w", dst_w_o, 0);

    // R8: asynchronous reset mid-cycle
    drive(6'h23, 5'd13);
    step();
    step();
    step();
    step();
    #1 rst_ni = 1'b0;
    #1;
    chk("R8 async ex", ex_ctrl_o, 0);
    chk("R8 async mem", mem_ctrl_o, 0);
    chk("R8 async wb", wb_ctrl_o, 0);
    chk("R8 async dst_e", dst_e_o, 0);
    chk("R8 async dst_m", dst_m_o, 0);
    chk("R8 async dst_w", dst_w_o, 0);
    step();
    rst_ni = 1'b1;
    step();
    step();
    chk("R3 after reset ex", ex_ctrl_o, 4'b0001);

    finish_run();
  end

endmodule